// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This block sequences the exception-return instruction of a small 32-bit processor core. When the core decodes the instruction it sends a one-cycle start pulse with the current supervisor stack pointer and the address of the return instruction. The unwinder then reads the first stacked longword over a simple request/valid memory port and takes a 4-bit frame format code from its top nibble.

A code of 4 to 7 marks a good frame. For a good frame, the unwinder keeps the low half of the first longword as the status register image and reads the second longword, which is the return address. It then commits three values in the same cycle: the status register, the new program counter, and a new stack pointer. The new stack pointer is the address just past the first longword plus the format code, so any alignment padding is removed with the frame.

Any other code aborts the return. This covers old-style frames, whose top longword has bit 30 clear. The unwinder reports a format error together with the address of the return instruction and does not touch the stack pointer, so a handler can build its own frame above the untouched one. A bus error on either read ends the sequence with a fault pulse and commits nothing.

Top module: `rteUnwinder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, memReq, done, fmtErr and busFault are low, and newSr, newPc, newSp and fmtErrPc are zero.
- R2: A startPulse seen while idle captures curSp and rteAddr. From the next cycle, memReq is high with memAddr equal to the captured stack pointer, and both stay unchanged until a cycle with memValid or memErr high.
- R3: The format code is memData[31:28] of the first read. When that code is 4, 5, 6 or 7, memReq stays high in the following cycle and memAddr becomes the captured stack pointer plus 4.
- R4: When the format code is any other value, the cycle after the first response has fmtErr high for one cycle and memReq low. fmtErrPc then holds the captured rteAddr. No second read is issued, done does not pulse, and newSr, newPc and newSp keep their values. A first longword with bit 30 clear always takes this path.
- R5: In the cycle after the second read's response, done is high for one cycle. In that same cycle newSr equals bits 15:0 of the first longword, newPc equals the second longword, and newSp equals the captured stack pointer plus 4 plus the format code, modulo 2^32. newSr, newPc and newSp change in no cycle where done is low.
- R6: memErr during either read makes busFault high for one cycle in the next cycle. busy is low in that cycle, done does not pulse, and newSr, newPc, newSp and fmtErrPc keep their values.
- R7: A startPulse while busy is high is ignored. The running sequence completes with results based on the stack pointer captured first.
- R8: busy is high from the cycle after an accepted start until the sequence ends. It is low in the cycle where done, fmtErr or busFault is high.
- R9: Each accepted start produces exactly one of done, fmtErr or busFault, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to run an exception return |
| curSp | input | 32 | Supervisor stack pointer at start |
| rteAddr | input | 32 | Address of the return instruction |
| memReq | output | 1 | Longword read request, held until answered |
| memAddr | output | 32 | Read address |
| memValid | input | 1 | Read data valid for the pending request |
| memData | input | 32 | Read data |
| memErr | input | 1 | Bus error for the pending request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: newSr, newPc, newSp just committed |
| newSr | output | 16 | Restored status register |
| newPc | output | 32 | Return program counter |
| newSp | output | 32 | Unwound stack pointer |
| fmtErr | output | 1 | One-cycle format-error request |
| fmtErrPc | output | 32 | Faulting PC reported with fmtErr |
| busFault | output | 1 | One-cycle bus fault during the unwind |

## Verification
The properties assume that memory answers only while memReq is high, that memValid and memErr are never high together, and that every response belongs to the read now pending. They also assume that memData carries the longword of the pending read in the response cycle. The stimulus uses a word-indexed memory model that drives responses only while a request is outstanding. It raises exactly one of memValid and memErr after a chosen wait of zero to three cycles. Each stack frame is loaded before its start pulse, and no frame word changes while a sequence is running.

// File: rtl/uwPkg.sv
package uwPkg;

  typedef enum logic [1:0] {
    UW_IDLE     = 2'd0,
    UW_FETCH_SR = 2'd1,
    UW_FETCH_PC = 2'd2
  } uwState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureArgs;  // latch stack pointer and return-instruction address
    logic captureSr;    // keep status image and format of a good frame
    logic captureErr;   // publish faulting PC
    logic commit;       // write SR, PC and SP together
    logic pickSecond;   // address the second longword
  } uwStrobes_t;

endpackage

// File: rtl/uwDatapath.sv
module uwDatapath
  import uwPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SR_W    = 16,
  parameter int FMT_W   = 4,
  parameter int FMT_LSB = 28,
  parameter int FMT_MIN = 4,
  parameter int FMT_MAX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  uwStrobes_t        strobes,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [ADDR_W-1:0] rteAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              fmtOk,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SR_W-1:0]   newSr,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSp,
  output logic [ADDR_W-1:0] fmtErrPc
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] spReg;
  logic [ADDR_W-1:0] retPcReg;
  logic [SR_W-1:0]   srStage;
  logic [FMT_W-1:0]  fmtStage;
  logic [FMT_W-1:0]  fmtField;
  logic [ADDR_W-1:0] spAfterFirst;

  assign fmtField     = memData[FMT_LSB +: FMT_W];
  assign fmtOk        = (fmtField >= FMT_W'(FMT_MIN)) && (fmtField <= FMT_W'(FMT_MAX));
  assign spAfterFirst = spReg + STEP;
  assign memAddr      = strobes.pickSecond ? spAfterFirst : spReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg    <= '0;
      retPcReg <= '0;
      srStage  <= '0;
      fmtStage <= '0;
    end else begin
      if (strobes.captureArgs) begin
        spReg    <= curSp;
        retPcReg <= rteAddr;
      end
      if (strobes.captureSr) begin
        srStage  <= memData[SR_W-1:0];
        fmtStage <= fmtField;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newSr    <= '0;
      newPc    <= '0;
      newSp    <= '0;
      fmtErrPc <= '0;
    end else begin
      if (strobes.commit) begin
        newSr <= srStage;
        newPc <= memData[ADDR_W-1:0];
        newSp <= spAfterFirst + ADDR_W'(fmtStage);
      end
      if (strobes.captureErr) begin
        fmtErrPc <= retPcReg;
      end
    end
  end

endmodule

// File: rtl/uwControl.sv
module uwControl
  import uwPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       memValid,
  input  logic       memErr,
  input  logic       fmtOk,
  output uwStrobes_t strobes,
  output logic       memReq,
  output logic       busy,
  output logic       done,
  output logic       fmtErr,
  output logic       busFault
);

  uwState_t state;
  uwState_t stateNext;
  logic     gotData;

  assign gotData = memValid && !memErr;
  assign memReq  = (state != UW_IDLE);
  assign busy    = memReq;

  always_comb begin
    strobes             = '0;
    strobes.captureArgs = (state == UW_IDLE) && startPulse;
    strobes.captureSr   = (state == UW_FETCH_SR) && gotData && fmtOk;
    strobes.captureErr  = (state == UW_FETCH_SR) && gotData && !fmtOk;
    strobes.commit      = (state == UW_FETCH_PC) && gotData;
    strobes.pickSecond  = (state == UW_FETCH_PC);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      UW_IDLE:     if (startPulse) stateNext = UW_FETCH_SR;
      UW_FETCH_SR: begin
        if (memErr)       stateNext = UW_IDLE;
        else if (memValid) stateNext = fmtOk ? UW_FETCH_PC : UW_IDLE;
      end
      UW_FETCH_PC: if (memErr || memValid) stateNext = UW_IDLE;
      default:     stateNext = UW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= UW_IDLE;
      done     <= 1'b0;
      fmtErr   <= 1'b0;
      busFault <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= strobes.commit;
      fmtErr   <= strobes.captureErr;
      busFault <= memReq && memErr;
    end
  end

endmodule

// File: rtl/rteUnwinder.sv
module rteUnwinder
  import uwPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SR_W    = 16,
  parameter int FMT_W   = 4,
  parameter int FMT_LSB = 28,
  parameter int FMT_MIN = 4,
  parameter int FMT_MAX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [ADDR_W-1:0] rteAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  input  logic              memErr,
  output logic              busy,
  output logic              done,
  output logic [SR_W-1:0]   newSr,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSp,
  output logic              fmtErr,
  output logic [ADDR_W-1:0] fmtErrPc,
  output logic              busFault
);

  uwStrobes_t strobes;
  logic       fmtOk;

  uwControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .memValid  (memValid),
    .memErr    (memErr),
    .fmtOk     (fmtOk),
    .strobes   (strobes),
    .memReq    (memReq),
    .busy      (busy),
    .done      (done),
    .fmtErr    (fmtErr),
    .busFault  (busFault)
  );

  uwDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SR_W   (SR_W),
    .FMT_W  (FMT_W),
    .FMT_LSB(FMT_LSB),
    .FMT_MIN(FMT_MIN),
    .FMT_MAX(FMT_MAX)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .curSp   (curSp),
    .rteAddr (rteAddr),
    .memData (memData),
    .fmtOk   (fmtOk),
    .memAddr (memAddr),
    .newSr   (newSr),
    .newPc   (newPc),
    .newSp   (newSp),
    .fmtErrPc(fmtErrPc)
  );

endmodule

// File: rtl/uwChecker.sv
module uwChecker #(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic [3:0]        fmtNibble,
  input logic              memErr,
  input logic              busy,
  input logic              done,
  input logic [SR_W-1:0]   newSr,
  input logic [ADDR_W-1:0] newPc,
  input logic [ADDR_W-1:0] newSp,
  input logic              fmtErr,
  input logic              busFault
);

  logic inSecond;
  logic fmtGood;

  assign fmtGood = (fmtNibble >= 4'd4) && (fmtNibble <= 4'd7);

  always_ff @(posedge clk) begin
    if (!rstN)                  inSecond <= 1'b0;
    else if (memReq && memErr)  inSecond <= 1'b0;
    else if (memReq && memValid) inSecond <= inSecond ? 1'b0 : fmtGood;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid && !memErr |=> memReq && $stable(memAddr));

  assert_second_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memValid && !memErr && !inSecond && fmtGood
      |=> memReq && (memAddr == $past(memAddr) + ADDR_W'(4)));

  assert_bad_fmt_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memValid && !memErr && !inSecond && !fmtGood |=> fmtErr && !memReq && !done);

  assert_commit_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({newSr, newPc, newSp}));

  assert_fault_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memErr |=> busFault && !done && !busy);

  assert_idle_on_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done || fmtErr || busFault) |-> !busy);

  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, fmtErr, busFault}));

endmodule

bind rteUnwinder uwChecker #(.ADDR_W(ADDR_W), .SR_W(SR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memValid (memValid),
  .fmtNibble(memData[31:28]),
  .memErr   (memErr),
  .busy     (busy),
  .done     (done),
  .newSr    (newSr),
  .newPc    (newPc),
  .newSp    (newSp),
  .fmtErr   (fmtErr),
  .busFault (busFault)
);

// File: tb/sim_rteUnwinder.sv
module sim_rteUnwinder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] curSp = '0;
  logic [31:0] rteAddr = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        memErr = 1'b0;
  logic        busy, done, fmtErr, busFault;
  logic [15:0] newSr;
  logic [31:0] newPc, newSp, fmtErrPc;

  always #4 clk = ~clk;

  rteUnwinder u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .curSp(curSp), .rteAddr(rteAddr),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .memErr(memErr), .busy(busy), .done(done), .newSr(newSr), .newPc(newPc),
    .newSp(newSp), .fmtErr(fmtErr), .fmtErrPc(fmtErrPc), .busFault(busFault)
  );

  int vectors = 0;
  int miscompares = 0;
  bit runOver = 0;

  // memory model state
  logic [31:0] mem [64];
  int lat = 0;
  int errOn = 0;
  int rdIdx = 0;
  int waitCnt = 0;

  // behavioural reference
  int          mPh = 0;
  logic [31:0] mSp = '0, mPc0 = '0;
  logic [15:0] mSr = '0;
  int          mFmt = 0;
  logic [15:0] eSr = '0;
  logic [31:0] ePc = '0, eSp = '0, eErrPc = '0;
  bit          eDone = 0, eFmt = 0, eBus = 0;
  bit          sawDone = 0, sawFmt = 0, sawBus = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mSp = '0; mPc0 = '0; mSr = '0; mFmt = 0;
      eSr = '0; ePc = '0; eSp = '0; eErrPc = '0;
      eDone = 0; eFmt = 0; eBus = 0;
    end else begin
      eDone = 0; eFmt = 0; eBus = 0;
      if (mPh == 0) begin
        if (startPulse) begin mSp = curSp; mPc0 = rteAddr; mPh = 1; end
      end else if (mPh == 1) begin
        if (memErr) begin eBus = 1; mPh = 0; end
        else if (memValid) begin
          if (memData[31:28] >= 4 && memData[31:28] <= 7) begin
            mSr = memData[15:0]; mFmt = int'(memData[31:28]); mPh = 2;
          end else begin
            eFmt = 1; eErrPc = mPc0; mPh = 0;
          end
        end
      end else begin
        if (memErr) begin eBus = 1; mPh = 0; end
        else if (memValid) begin
          eSr = mSr; ePc = memData; eSp = mSp + 32'd4 + 32'(mFmt); eDone = 1; mPh = 0;
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !runOver) begin
      logic [31:0] xAddr;
      xAddr = (mPh == 1) ? mSp : mSp + 32'd4;
      check(memReq == (mPh != 0), "R2 memReq", 32'(memReq), 32'(mPh != 0));
      if (mPh != 0) check(memAddr == xAddr, (mPh == 1) ? "R2 memAddr" : "R3 memAddr", memAddr, xAddr);
      check(busy == (mPh != 0), "R8 busy", 32'(busy), 32'(mPh != 0));
      check(done == eDone, "R5 done", 32'(done), 32'(eDone));
      check(fmtErr == eFmt, "R4 fmtErr", 32'(fmtErr), 32'(eFmt));
      check(busFault == eBus, "R6 busFault", 32'(busFault), 32'(eBus));
      check(newSr == eSr, "R5 newSr", 32'(newSr), 32'(eSr));
      check(newPc == ePc, "R5 newPc", newPc, ePc);
      check(newSp == eSp, "R5 newSp", newSp, eSp);
      check(fmtErrPc == eErrPc, "R4 fmtErrPc", fmtErrPc, eErrPc);
      check($countones({done, fmtErr, busFault}) <= 1, "R9 single result", 32'({done, fmtErr, busFault}), 32'd0);
      if (done) sawDone = 1;
      if (fmtErr) sawFmt = 1;
      if (busFault) sawBus = 1;
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      memErr   = 1'b0;
      if (memReq) begin
        if (waitCnt >= lat) begin
          rdIdx++;
          if (errOn == rdIdx) memErr = 1'b1;
          else begin memValid = 1'b1; memData = mem[memAddr[7:2]]; end
          waitCnt = 0;
        end else waitCnt++;
      end else waitCnt = 0;
    end
  end

  task automatic runRte(input logic [31:0] sp, input logic [31:0] pc, input logic [31:0] w0,
                        input logic [31:0] w1, input int errSel, input int latency, input bit midStart);
    logic [31:0] spNext;
    logic [15:0] srBefore;
    logic [31:0] pcBefore, spBefore, errBefore;
    bit good;
    spNext = sp + 32'd4;
    mem[sp[7:2]] = w0;
    mem[spNext[7:2]] = w1;
    errOn = errSel; lat = latency; rdIdx = 0;
    srBefore = newSr; pcBefore = newPc; spBefore = newSp; errBefore = fmtErrPc;
    sawDone = 0; sawFmt = 0; sawBus = 0;
    good = (w0[31:28] >= 4) && (w0[31:28] <= 7);
    curSp = sp; rteAddr = pc; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    curSp = 32'h5A5A_0100; rteAddr = 32'h0BAD_0000;
    for (int i = 0; i < 24; i++) begin
      startPulse = (midStart && i == 0);
      @(negedge clk);
    end
    startPulse = 1'b0;
    if (errSel == 1 || (errSel == 2 && good)) begin
      check(sawBus && !sawDone && !sawFmt, "R6 fault only", 32'({sawDone, sawFmt, sawBus}), 32'b001);
      check(newSp == spBefore && newPc == pcBefore && newSr == srBefore, "R6 no commit SP", newSp, spBefore);
      check(fmtErrPc == errBefore, "R6 no commit errPc", fmtErrPc, errBefore);
    end else if (!good) begin
      check(sawFmt && !sawDone && !sawBus, "R4 format error only", 32'({sawDone, sawFmt, sawBus}), 32'b010);
      check(fmtErrPc == pc, "R4 faulting PC", fmtErrPc, pc);
      check(newSp == spBefore, "R4 stack untouched", newSp, spBefore);
    end else begin
      check(sawDone && !sawFmt && !sawBus, "R9 done only", 32'({sawDone, sawFmt, sawBus}), 32'b100);
      check(newSr == w0[15:0], "R5 SR from first longword", 32'(newSr), 32'(w0[15:0]));
      check(newPc == w1, "R5 PC from second longword", newPc, w1);
      check(newSp == sp + 32'd4 + 32'(w0[31:28]), midStart ? "R7 first SP used" : "R5 SP unwound",
            newSp, sp + 32'd4 + 32'(w0[31:28]));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'(i) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    check(!busy && !memReq && !done && !fmtErr && !busFault, "R1 reset flags",
          32'({busy, memReq, done, fmtErr, busFault}), 32'd0);
    check(newSr == 16'd0 && newPc == 32'd0 && newSp == 32'd0 && fmtErrPc == 32'd0, "R1 reset values", newSp, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R1 idle after reset", 32'({busy, memReq}), 32'd0);

    runRte(32'h2000_0040, 32'h0000_1000, 32'h4000_2704, 32'h0000_8000, 0, 0, 0); // R5 fmt 4
    runRte(32'h2000_0080, 32'h0000_1004, 32'h7123_2011, 32'h0000_9002, 0, 2, 0); // R5 fmt 7
    runRte(32'h2000_0010, 32'h0000_1008, 32'h5000_0700, 32'h1234_5678, 0, 1, 0); // R3 fmt 5
    runRte(32'h2000_00C0, 32'h0000_100C, 32'h6FFF_FFFF, 32'hCAFE_0000, 0, 3, 0); // R3 fmt 6
    runRte(32'h2000_0020, 32'h0000_2000, 32'h0000_2700, 32'h0000_4444, 0, 0, 0); // R4 old frame, bit30 clear
    runRte(32'h2000_0030, 32'h0000_2004, 32'hF000_0001, 32'h0000_4448, 0, 1, 0); // R4 fmt 15
    runRte(32'h2000_0050, 32'h0000_2008, 32'h3000_0002, 32'h0000_444C, 0, 0, 0); // R4 fmt 3
    runRte(32'h2000_0060, 32'h0000_200C, 32'h8000_0003, 32'h0000_4450, 0, 2, 0); // R4 fmt 8
    runRte(32'h2000_0070, 32'h0000_3000, 32'h4000_0100, 32'h0000_5000, 1, 1, 0); // R6 first read error
    runRte(32'h2000_0090, 32'h0000_3004, 32'h6000_0200, 32'h0000_5004, 2, 0, 0); // R6 second read error
    runRte(32'h2000_00A0, 32'h0000_3008, 32'h5000_0300, 32'h0000_6000, 0, 3, 1); // R7 start while busy
    runRte(32'hFFFF_FFF8, 32'h0000_300C, 32'h7000_ABCD, 32'h0000_7000, 0, 0, 0); // R5 SP wraps

    runOver = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!runOver) begin
      runOver = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule